// File: doc/BRIEF.md
# Product-Term Cluster Steering Router

This block routes product-term clusters to macrocells in a small programmable-logic fabric. Each cluster arrives already reduced to a single OR term. A per-cluster steering setting sends that term to one macrocell in a short run of neighbouring macrocells. Every macrocell output is the OR of all clusters currently sent to it. The data path from clusters to macrocells is purely combinational. The steering settings live in a small register file, loaded one cluster at a time through a write port and then held static.

Cluster j can reach four macrocells: M(j-2), M(j-1), Mj and M(j+1). Put the other way, macrocell Mi draws from C(i-1) through C(i+2). At both ends of the array the window is cut short, so some settings are illegal. The block detects any enabled setting whose target lies outside the array. It raises an error flag for it and drops that cluster's contribution. A parameter sets the array size to 16 or 12 macrocells; the number of clusters always equals the number of macrocells.

Top module: `pt_cluster_steer`

## Requirements
- R1: While `rst` is high at a clock edge, every cluster setting is cleared to disabled. After reset, `mc_out` is all zero and `cfg_err` is 0 whatever `cl_in` holds.
- R2: When `cfg_we` is high at a rising edge, `cfg_data` is stored as the setting of cluster `cfg_addr`. Addresses at or above the macrocell count are ignored. The outputs follow the new setting from that edge on. With `cfg_we` low, the settings, `cfg_err` and, for steady `cl_in`, `mc_out` do not change.
- R3: `cfg_data[2]` is the enable bit and `cfg_data[1:0]` is the offset. An enabled cluster j with offset k drives exactly one macrocell, number j-2+k: offset 0 is M(j-2), 1 is M(j-1), 2 is Mj and 3 is M(j+1).
- R4: A cluster whose enable bit is 0 drives no macrocell.
- R5: Each `mc_out` bit is the OR of every cluster steered to that macrocell. A bit is 0 when no cluster is steered to it, or when all clusters steered to it are low.
- R6: At the low end, offsets 0 and 1 are illegal for C0 and offset 0 is illegal for C1. Offsets 2 and 3 of C0 reach M0 and M1.
- R7: At the high end, offset 3 is illegal for the last cluster. Its offsets 0, 1 and 2 reach the last three macrocells.
- R8: Any enabled cluster with an illegal offset sets `cfg_err` and contributes to no macrocell. `cfg_err` falls as soon as every such setting is corrected or disabled.
- R9: With `NUM_MC` = 12, the same window pattern applies to C0 through C11. C11 offset 3 is illegal, C11 offset 2 reaches M11, and C10 offset 3 reaches M11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the setting registers |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write enable for one cluster setting |
| cfg_addr | input | ADDR_W | Index of the cluster being written |
| cfg_data | input | 3 | Setting: bit 2 enable, bits 1:0 offset |
| cl_in | input | NUM_MC | Reduced product-term clusters C0 upward |
| mc_out | output | NUM_MC | Per-macrocell OR of steered clusters |
| cfg_err | output | 1 | Some enabled setting targets outside the array |

## Verification
Every cluster is tried with every offset, with only that cluster high. This shows that each cluster reaches exactly the macrocell its offset names, and that only the edge offsets are flagged. A cumulative sequence of writes then steers several clusters onto overlapping macrocells. This separates the OR merging from a plain overwrite and shows that disabling one cluster leaves its neighbours alone. Directed cases at both ends of the array check that an illegal setting lights nothing while the flag is raised, and that the flag clears when the setting is fixed. The 12-macrocell instance checks that its top edge is cut at C11. A write with the enable low, and a second reset, check that settings hold and clear.

// File: rtl/pt_steer_pkg.sv
package pt_steer_pkg;

    // Number of macrocells a single cluster can reach.
    localparam int WIN_SPAN = 4;
    // Offset value that lands on the cluster's own macrocell index.
    localparam int WIN_BASE = 2;
    localparam int OFF_W    = $clog2(WIN_SPAN);

    typedef struct packed {
        logic             en;
        logic [OFF_W-1:0] off;
    } steer_cfg_t;

    localparam int CFG_W = $bits(steer_cfg_t);

endpackage

// File: rtl/steer_cfg_regs.sv
module steer_cfg_regs
    import pt_steer_pkg::*;
#(
    parameter int NUM_MC = 16,
    parameter int ADDR_W = $clog2(NUM_MC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  steer_cfg_t              wdata,
    output steer_cfg_t [NUM_MC-1:0] cfg_q
);

    for (genvar j = 0; j < NUM_MC; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[j] <= '0;
            end else if (we && (int'(addr) == j)) begin
                cfg_q[j] <= wdata;
            end
        end
    end

endmodule

// File: rtl/steer_decode.sv
module steer_decode
    import pt_steer_pkg::*;
#(
    parameter int NUM_MC = 16
) (
    input  steer_cfg_t [NUM_MC-1:0]             cfg_q,
    output logic [NUM_MC-1:0][NUM_MC-1:0]       tgt_oh,
    output logic [NUM_MC-1:0]                   err_vec
);

    for (genvar j = 0; j < NUM_MC; j++) begin : g_cl
        int tgt;
        always_comb begin
            tgt        = j - WIN_BASE + int'(cfg_q[j].off);
            tgt_oh[j]  = '0;
            err_vec[j] = 1'b0;
            if (cfg_q[j].en) begin
                if (tgt < 0 || tgt >= NUM_MC) begin
                    err_vec[j] = 1'b1;
                end else begin
                    for (int m = 0; m < NUM_MC; m++) begin
                        if (m == tgt) tgt_oh[j][m] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/steer_or_matrix.sv
module steer_or_matrix #(
    parameter int NUM_MC = 16
) (
    input  logic [NUM_MC-1:0]               cl_in,
    input  logic [NUM_MC-1:0][NUM_MC-1:0]   tgt_oh,
    output logic [NUM_MC-1:0]               mc_out
);

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        always_comb begin
            mc_out[m] = 1'b0;
            for (int j = 0; j < NUM_MC; j++) begin
                mc_out[m] = mc_out[m] | (cl_in[j] & tgt_oh[j][m]);
            end
        end
    end

endmodule

// File: rtl/pt_cluster_steer.sv
module pt_cluster_steer
    import pt_steer_pkg::*;
#(
    parameter int NUM_MC = 16,
    parameter int ADDR_W = $clog2(NUM_MC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [NUM_MC-1:0] cl_in,
    output logic [NUM_MC-1:0] mc_out,
    output logic              cfg_err
);

    steer_cfg_t [NUM_MC-1:0]           cfg_q;
    logic [NUM_MC-1:0][NUM_MC-1:0]     tgt_oh;
    logic [NUM_MC-1:0]                 err_vec;

    steer_cfg_regs #(.NUM_MC(NUM_MC), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (steer_cfg_t'(cfg_data)),
        .cfg_q (cfg_q)
    );

    steer_decode #(.NUM_MC(NUM_MC)) u_dec (
        .cfg_q   (cfg_q),
        .tgt_oh  (tgt_oh),
        .err_vec (err_vec)
    );

    steer_or_matrix #(.NUM_MC(NUM_MC)) u_or (
        .cl_in  (cl_in),
        .tgt_oh (tgt_oh),
        .mc_out (mc_out)
    );

    assign cfg_err = |err_vec;

endmodule

// File: rtl/pt_cluster_steer_chk.sv
module pt_cluster_steer_chk #(
    parameter int NUM_MC = 16
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            cfg_we,
    input logic [NUM_MC-1:0]               cl_in,
    input logic [NUM_MC-1:0]               mc_out,
    input logic                            cfg_err,
    input logic [NUM_MC-1:0][NUM_MC-1:0]   tgt_oh,
    input logic [NUM_MC-1:0]               err_vec
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cfg_err && mc_out == '0)); // R1

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_err)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we) && $stable(cl_in)) |-> $stable(mc_out)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cl_in == '0) |-> (mc_out == '0)); // R5

    for (genvar j = 0; j < NUM_MC; j++) begin : g_cl
        AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
            $onehot0(tgt_oh[j])); // R3

        AST_ERR_MASK: assert property (@(posedge clk) disable iff (rst)
            err_vec[j] |-> (tgt_oh[j] == '0)); // R8
    end

endmodule

bind pt_cluster_steer pt_cluster_steer_chk #(.NUM_MC(NUM_MC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cl_in   (cl_in),
    .mc_out  (mc_out),
    .cfg_err (cfg_err),
    .tgt_oh  (tgt_oh),
    .err_vec (err_vec)
);

// File: tb/pt_cluster_steer_test.sv
module pt_cluster_steer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [2:0]  cfg_data = '0;
    logic [15:0] cl_in = '0;
    logic [15:0] mc_out;
    logic        cfg_err;

    logic        s_we = 1'b0;
    logic [3:0]  s_addr = '0;
    logic [2:0]  s_data = '0;
    logic [11:0] s_cl = '0;
    logic [11:0] s_out;
    logic        s_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pt_cluster_steer #(.NUM_MC(16)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cl_in(cl_in), .mc_out(mc_out), .cfg_err(cfg_err)
    );

    pt_cluster_steer #(.NUM_MC(12)) uut_small (
        .clk(clk), .rst(rst), .cfg_we(s_we), .cfg_addr(s_addr),
        .cfg_data(s_data), .cl_in(s_cl), .mc_out(s_out), .cfg_err(s_err)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic [2:0]  data;
        logic [15:0] cl;
        logic [15:0] exp_out;
        logic        exp_err;
    } vec_t;

    // Cumulative: each entry writes one setting, then applies a cluster pattern.
    localparam vec_t VEC [6] = '{
        '{4'd5, 3'b110, 16'h0020, 16'h0020, 1'b0},
        '{4'd6, 3'b100, 16'h0060, 16'h0030, 1'b0},
        '{4'd7, 3'b101, 16'h00E0, 16'h0070, 1'b0},
        '{4'd8, 3'b111, 16'h01E0, 16'h0270, 1'b0},
        '{4'd4, 3'b111, 16'h0030, 16'h0020, 1'b0},
        '{4'd5, 3'b010, 16'h01F0, 16'h0270, 1'b0}
    };

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; s_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [2:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_s(logic [3:0] a, logic [2:0] d);
        @(negedge clk);
        s_we = 1'b1; s_addr = a; s_data = d;
        @(negedge clk);
        s_we = 1'b0;
    endtask

    task automatic apply(logic [15:0] c);
        cl_in = c;
        #2;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cl_in = 16'hFFFF;
        s_cl  = 12'hFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check("R1 reset out", mc_out, 16'h0000);
        check("R1 reset err", {15'd0, cfg_err}, 16'h0000);
        check("R1 reset small out", {4'd0, s_out}, 16'h0000);

        // Full sweep: one cluster, every offset.
        for (int j = 0; j < 16; j++) begin
            for (int k = 0; k < 4; k++) begin
                int t;
                logic [15:0] e;
                t = j - 2 + k;
                e = (t >= 0 && t < 16) ? (16'h0001 << t) : 16'h0000;
                wr(4'(j), {1'b1, 2'(k)});
                apply(16'h0001 << j);
                check("R3 sweep out", mc_out, e);
                check("R8 sweep err", {15'd0, cfg_err}, {15'd0, (e == 16'h0000)});
                apply(~(16'h0001 << j));
                check("R4 other clusters idle", mc_out, 16'h0000);
                wr(4'(j), 3'b000);
            end
        end

        // Cumulative vector table.
        for (int v = 0; v < 6; v++) begin
            wr(VEC[v].addr, VEC[v].data);
            apply(VEC[v].cl);
            check("R5 table out", mc_out, VEC[v].exp_out);
            check("R4 table err", {15'd0, cfg_err}, {15'd0, VEC[v].exp_err});
        end

        // Write enable low: settings hold.
        @(negedge clk);
        cfg_addr = 4'd4; cfg_data = 3'b100;
        @(negedge clk);
        @(negedge clk);
        apply(16'h01F0);
        check("R2 hold out", mc_out, 16'h0270);
        check("R2 hold err", {15'd0, cfg_err}, 16'h0000);

        // Low edge.
        do_reset();
        check("R1 second reset", mc_out, 16'h0000);
        wr(4'd0, 3'b100);
        apply(16'h0001);
        check("R6 C0 off0 out", mc_out, 16'h0000);
        check("R6 C0 off0 err", {15'd0, cfg_err}, 16'h0001);
        wr(4'd0, 3'b101);
        apply(16'h0001);
        check("R6 C0 off1 err", {15'd0, cfg_err}, 16'h0001);
        wr(4'd0, 3'b110);
        apply(16'h0001);
        check("R6 C0 off2 out", mc_out, 16'h0001);
        check("R8 err cleared", {15'd0, cfg_err}, 16'h0000);
        wr(4'd0, 3'b111);
        apply(16'h0001);
        check("R6 C0 off3 out", mc_out, 16'h0002);
        wr(4'd1, 3'b100);
        apply(16'h0003);
        check("R8 C1 off0 masked", mc_out, 16'h0002);
        check("R6 C1 off0 err", {15'd0, cfg_err}, 16'h0001);
        wr(4'd1, 3'b101);
        apply(16'h0003);
        check("R6 C1 off1 out", mc_out, 16'h0003);

        // High edge.
        do_reset();
        wr(4'd15, 3'b111);
        apply(16'h8000);
        check("R7 C15 off3 out", mc_out, 16'h0000);
        check("R7 C15 off3 err", {15'd0, cfg_err}, 16'h0001);
        wr(4'd15, 3'b110);
        apply(16'h8000);
        check("R7 C15 off2 out", mc_out, 16'h8000);
        wr(4'd15, 3'b100);
        apply(16'h8000);
        check("R7 C15 off0 out", mc_out, 16'h2000);
        check("R8 err after fix", {15'd0, cfg_err}, 16'h0000);

        // Twelve-macrocell instance.
        s_cl = 12'h800;
        wr_s(4'd11, 3'b111);
        #2;
        check("R9 C11 off3 out", {4'd0, s_out}, 16'h0000);
        check("R9 C11 off3 err", {15'd0, s_err}, 16'h0001);
        wr_s(4'd11, 3'b110);
        #2;
        check("R9 C11 off2 out", {4'd0, s_out}, 16'h0800);
        wr_s(4'd13, 3'b100);
        #2;
        check("R2 small high addr ignored", {4'd0, s_out}, 16'h0800);
        s_cl = 12'h400;
        wr_s(4'd11, 3'b000);
        wr_s(4'd10, 3'b111);
        #2;
        check("R9 C10 off3 out", {4'd0, s_out}, 16'h0800);
        check("R9 small err", {15'd0, s_err}, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule